// File: doc/BRIEF.md
# Dead-Time Search Sequencer

This block is a control state machine that finds the shortest safe dead time for one half-bridge switching transition. The dead time is held as a count of clock cycles. A search begins at a large value and walks it down by a fixed step. After each step the block closes an external switch that empties a peak-detect capacitor. It then waits a settle interval while the detector recharges to the new switching peak, and requests one ADC conversion of that peak.

While the dead time is still long, each sample is lower than the one before it, because reverse-recovery overshoot shrinks. Once the transistors start to conduct at the same time, the sample climbs again. The block treats a climb larger than a programmable margin as the start of cross-conduction. It then stops and moves the dead time back up by one step, which gives the result. If the dead time would pass below a programmable floor before any climb is seen, the search stops at the last value it measured and raises a flag. The result stays on the output until the next search is started.

Top module: `dead_time_seeker`

## Requirements
- R1: After reset the block is idle: `dt_o` equals DT_START, and `busy_o`, `done_o`, `discharge_o`, `adc_req_o` and `floor_hit_o` are all 0.
- R2: In the cycle after `start_i` is sampled high in the idle or done state, `busy_o` and `discharge_o` are 1 and `dt_o` equals DT_START. A `start_i` pulse during a search is ignored and does not change its result or its number of samples.
- R3: For every step, `discharge_o` stays high for exactly DISCH_CYC cycles. It is followed by exactly SETTLE_CYC cycles in which `discharge_o` and `adc_req_o` are both low, and then `adc_req_o` rises.
- R4: `adc_req_o` stays high until a cycle in which `adc_valid_i` is also high, and the sample `adc_data_i` is taken in that cycle. `adc_req_o` and `discharge_o` are never high together.
- R5: A taken sample that is not a rise, and that does not trigger the floor stop, lowers `dt_o` by DT_STEP and starts the next discharge. `dt_o` changes at no other time during a search.
- R6: A sample counts as a rise only when it is strictly greater than the previous sample plus `hyst_i`, unsigned. The first sample of a search is never a rise. On a rise `dt_o` goes up by DT_STEP and the search ends with `floor_hit_o` = 0.
- R7: If a taken sample is not a rise and `dt_o` - DT_STEP < `floor_i`, the search ends with `dt_o` unchanged and `floor_hit_o` = 1.
- R8: `done_o` is a single-cycle pulse. It is high in the cycle after the final sample is taken, and `busy_o` is 0 from then on. `dt_o` and `floor_hit_o` then hold until the next start.
- R9: A new start clears `floor_hit_o` and the stored previous sample, so each search is independent of earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (taken only when not busy) |
| floor_i | input | DT_W | Lowest dead time the search may set, in cycles |
| hyst_i | input | ADC_W | Margin a sample must exceed the previous one by to count as a rise |
| adc_req_o | output | 1 | Conversion request, held until accepted |
| adc_valid_i | input | 1 | Conversion result valid |
| adc_data_i | input | ADC_W | Sampled peak voltage code |
| discharge_o | output | 1 | Drives the capacitor discharge switch |
| dt_o | output | DT_W | Current dead time in clock cycles |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| floor_hit_o | output | 1 | Last search stopped at the floor rather than on a rise |

## Verification
The discharge output rises one cycle after start is sampled. It stays high for DISCH_CYC cycles, and after it falls the request rises SETTLE_CYC cycles later. A bench monitor measures every discharge run and every settle gap at the falling clock edge and compares each against these counts. The ADC model answers a request on the next falling edge. Each accepted sample therefore moves `dt_o` one cycle after the model drives valid, and the bench checks that `done_o` arrives exactly one cycle after the last valid it drove. Results are read only at falling edges, half a cycle after the register updates they depend on.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISCH,
    ST_SETTLE,
    ST_REQ,
    ST_DONE
  } dts_state_e;
endpackage

// File: rtl/dts_timer.sv
module dts_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dts_rise_det.sv
module dts_rise_det #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic [AW-1:0] sample_i,
  input  logic [AW-1:0] hyst_i,
  output logic          rise_o
);
  logic [AW-1:0] prev_q;
  logic          have_q;
  logic [AW:0]   limit;

  assign limit  = {1'b0, prev_q} + {1'b0, hyst_i};
  assign rise_o = have_q && ({1'b0, sample_i} > limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (clear_i) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (load_i) begin
      prev_q <= sample_i;
      have_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dts_dt_reg.sv
module dts_dt_reg #(
  parameter int DW       = 10,
  parameter int DT_START = 150,
  parameter int DT_STEP  = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          dec_i,
  input  logic          inc_i,
  input  logic [DW-1:0] floor_i,
  output logic [DW-1:0] dt_o,
  output logic          at_floor_o
);
  localparam logic [DW-1:0] START_V = DW'(DT_START);
  localparam logic [DW-1:0] STEP_V  = DW'(DT_STEP);
  localparam logic [DW:0]   STEP_X  = (DW+1)'(DT_STEP);

  // next step would fall below the floor
  assign at_floor_o = {1'b0, dt_o} < ({1'b0, floor_i} + STEP_X);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dt_o <= START_V;
    else if (init_i) dt_o <= START_V;
    else if (inc_i)  dt_o <= dt_o + STEP_V;
    else if (dec_i)  dt_o <= dt_o - STEP_V;
  end
endmodule

// File: rtl/dead_time_seeker.sv
module dead_time_seeker #(
  parameter int DT_W       = 10,
  parameter int ADC_W      = 12,
  parameter int DT_START   = 150,
  parameter int DT_STEP    = 10,
  parameter int DISCH_CYC  = 15000,
  parameter int SETTLE_CYC = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DT_W-1:0]  floor_i,
  input  logic [ADC_W-1:0] hyst_i,
  output logic             adc_req_o,
  input  logic             adc_valid_i,
  input  logic [ADC_W-1:0] adc_data_i,
  output logic             discharge_o,
  output logic [DT_W-1:0]  dt_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             floor_hit_o
);
  import dts_pkg::*;

  localparam int CMAX = (DISCH_CYC > SETTLE_CYC) ? DISCH_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DISCH_LAST  = CW'(DISCH_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  dts_state_e state_q, state_d;
  logic [CW-1:0] cnt;
  logic accept, rise, at_floor, init, dec, inc, stop_floor;

  assign accept     = (state_q == ST_REQ) && adc_valid_i;
  assign init       = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && start_i;
  assign inc        = accept && rise;
  assign stop_floor = accept && !rise && at_floor;
  assign dec        = accept && !rise && !at_floor;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_DISCH;
      ST_DONE:   state_d = start_i ? ST_DISCH : ST_IDLE;
      ST_DISCH:  if (cnt == DISCH_LAST) state_d = ST_SETTLE;
      ST_SETTLE: if (cnt == SETTLE_LAST) state_d = ST_REQ;
      ST_REQ:    if (adc_valid_i) state_d = (rise || at_floor) ? ST_DONE : ST_DISCH;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         floor_hit_o <= 1'b0;
    else if (init)       floor_hit_o <= 1'b0;
    else if (stop_floor) floor_hit_o <= 1'b1;
  end

  dts_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .cnt_o  (cnt)
  );

  dts_rise_det #(.AW(ADC_W)) u_rise (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (init),
    .load_i   (accept),
    .sample_i (adc_data_i),
    .hyst_i   (hyst_i),
    .rise_o   (rise)
  );

  dts_dt_reg #(.DW(DT_W), .DT_START(DT_START), .DT_STEP(DT_STEP)) u_dt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init),
    .dec_i      (dec),
    .inc_i      (inc),
    .floor_i    (floor_i),
    .dt_o       (dt_o),
    .at_floor_o (at_floor)
  );

  assign discharge_o = (state_q == ST_DISCH);
  assign adc_req_o   = (state_q == ST_REQ);
  assign busy_o      = (state_q == ST_DISCH) || (state_q == ST_SETTLE) || (state_q == ST_REQ);
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/dts_chk.sv
module dts_chk #(
  parameter int DT_W     = 10,
  parameter int DT_START = 150
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            adc_req_o,
  input logic            adc_valid_i,
  input logic            discharge_o,
  input logic [DT_W-1:0] dt_o,
  input logic            busy_o,
  input logic            done_o
);
  // R4
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(discharge_o && adc_req_o));
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && !adc_valid_i |=> adc_req_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R5
  dt_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(adc_req_o && adc_valid_i) |=> $stable(dt_o));
  // R6
  dt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_o <= DT_W'(DT_START));
  // R3
  disch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discharge_o |-> busy_o);
endmodule

bind dead_time_seeker dts_chk #(.DT_W(DT_W), .DT_START(DT_START)) u_dts_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .adc_req_o   (adc_req_o),
  .adc_valid_i (adc_valid_i),
  .discharge_o (discharge_o),
  .dt_o        (dt_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/dead_time_seeker_test.sv
module dead_time_seeker_test;
  localparam int DW = 8, AW = 10, START = 100, STEP = 10, DISCH = 20, SETTLE = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, valid = 1'b0;
  logic [DW-1:0] floor_v = '0;
  logic [AW-1:0] hyst = '0, data = '0;
  logic req, dis, busy, done, fhit;
  logic [DW-1:0] dt;

  int n_chk = 0, n_bad = 0, cyc = 0, last_v_cyc = 0, n_smp = 0, tim_err = 0;
  int mode = 0, knee = 0, dis_run = 0, gap_run = 0;
  logic prev_dis = 1'b0, prev_req = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  dead_time_seeker #(.DT_W(DW), .ADC_W(AW), .DT_START(START), .DT_STEP(STEP),
                     .DISCH_CYC(DISCH), .SETTLE_CYC(SETTLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .floor_i(floor_v), .hyst_i(hyst),
    .adc_req_o(req), .adc_valid_i(valid), .adc_data_i(data), .discharge_o(dis),
    .dt_o(dt), .busy_o(busy), .done_o(done), .floor_hit_o(fhit));

  function automatic int model(int d);
    case (mode)
      1:       return (d >= knee) ? d : 2 * knee - d;
      2:       return (d >= knee) ? d : knee + 3;
      default: return d;
    endcase
  endfunction

  // ADC model: answers a request on the next falling edge
  always @(negedge clk) begin
    if (req && !valid) begin
      valid = 1'b1;
      data = AW'(model(int'(dt)));
      n_smp++;
      last_v_cyc = cyc;
    end else valid = 1'b0;
  end

  // phase timing monitor (R3, R4)
  always @(negedge clk) begin
    if (rst_n) begin
      if (dis && req) tim_err++;
      if (dis) dis_run++;
      else if (prev_dis) begin
        if (dis_run != DISCH) tim_err++;
        dis_run = 0;
      end
      if (busy && !dis && !req) gap_run++;
      if (req && !prev_req) begin
        if (gap_run != SETTLE) tim_err++;
        gap_run = 0;
      end
    end
    prev_dis = dis;
    prev_req = req;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_search(input int md, input int kn, input int hy, input int fl,
                            input bit mid_start, input int exp_dt, input bit exp_fl,
                            input int exp_smp, input string tag);
    bit seen = 1'b0;
    @(negedge clk);
    mode = md; knee = kn; hyst = AW'(hy); floor_v = DW'(fl);
    n_smp = 0; tim_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 begin of search
    chk(dis && busy && dt == DW'(START), {tag, " R2 start"}, int'(dt), START);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
      start = (mid_start && i == 100);
    end
    start = 1'b0;
    chk(seen, {tag, " R8 done seen"}, int'(seen), 1);
    // R8 done one cycle after last sample
    chk(cyc - last_v_cyc == 1, {tag, " R8 done latency"}, cyc - last_v_cyc, 1);
    // R5 R6 R7 result
    chk(dt == DW'(exp_dt), {tag, " R5/R6/R7 dt"}, int'(dt), exp_dt);
    chk(fhit == exp_fl, {tag, " R7 floor flag"}, int'(fhit), int'(exp_fl));
    chk(n_smp == exp_smp, {tag, " R5 sample count"}, n_smp, exp_smp);
    chk(tim_err == 0, {tag, " R3/R4 phase timing"}, tim_err, 0);
    @(negedge clk);
    chk(!done && !busy, {tag, " R8 single pulse"}, int'(done), 0);
    repeat (10) @(negedge clk);
    chk(dt == DW'(exp_dt) && fhit == exp_fl && !busy, {tag, " R8 result held"}, int'(dt), exp_dt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dt == DW'(START), "R1 dt", int'(dt), START);
    chk(!busy && !done && !dis && !req && !fhit, "R1 flags", int'({busy, done, dis, req, fhit}), 0);

    // R6 V-shaped response: rise at 50, back off to 60
    run_search(1, 60, 0, 20, 1'b0, 60, 1'b0, 6, "A");
    // R6 step of exactly hyst is not a rise, so floor stop (R7)
    run_search(2, 60, 3, 20, 1'b0, 20, 1'b1, 9, "B");
    // R6 step greater than hyst is a rise
    run_search(2, 60, 2, 20, 1'b0, 60, 1'b0, 6, "C");
    // R7 floor not on step grid
    run_search(0, 0, 0, 25, 1'b0, 30, 1'b1, 8, "D");
    // R6 R9 rise on second sample, flag cleared, back to start
    run_search(1, 100, 0, 20, 1'b0, 100, 1'b0, 2, "E");
    // R7 floor just under start: one sample only
    run_search(0, 0, 0, 95, 1'b0, 100, 1'b1, 1, "F");
    // R2 start during search ignored
    run_search(1, 60, 0, 20, 1'b1, 60, 1'b0, 6, "G");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule